// File: doc/BRIEF.md
# SMBus Configuration Command Engine

This block lets a sideband management port start configuration-space reads and writes. A byte-wide register port is driven by an SMBus slave that has already decoded the bus traffic. Through this port the slave reaches a bank of eight byte registers:

- a shared command/status byte, which takes a command when written and returns status when read;
- three target-address bytes: bus, device/function and register index;
- a four-byte data word.

A write of a valid command, with its enable bit set, makes the engine busy. While busy, it presents one request on a simple configuration master interface. The request carries:

- an aligned register index;
- per-lane byte enables;
- write data placed in the correct lanes;
- a read/write flag.

The request stays up until the target responds with completion or abort.

The register port follows valid/ready rules without back-pressure queuing. `reg_ready` is low for the whole time a command is in flight. A request presented while `reg_ready` is low is refused, which the SMBus slave turns into a NACK. A refused request is dropped, not held: it writes nothing and its read data is meaningless. When `reg_ready` is high, a request is taken in the cycle it is presented, and its read data is valid in that same cycle.

On the master side, `cfg_req` acts as valid. A single-cycle `cfg_done` or `cfg_abort` pulse ends the transfer. Read data is sampled on `cfg_done`.

Top module: `smb_cfg_engine`

## Requirements
- R1: After reset, `reg_ready` is 1 and `cfg_req` is 0. Every register byte, including status, reads 0x00.
- R2: The register offsets are 0 command/status, 1 bus, 2 device/function and 3 register index. Offsets 4..7 hold data word bits [7:0], [15:8], [23:16] and [31:24]. When idle, bytes written to offsets 1..7 read back unchanged.
- R3: The status byte read at offset 0 has the error flag in bit 7, zeros in bits 6:4, the enable bit in bit 3 and the command field in bits 2:0.
- R4: The command codes are 001 byte write, 010 word write, 011 dword write and 100 dword read. A write to offset 0 with bit 3 set and one of these codes clears the error flag. From the next cycle, it holds `cfg_req` high and `reg_ready` low.
- R5: While a command is in flight, any register request is refused and changes no register.
- R6: Once raised, `cfg_req` and all request fields stay stable until a `cfg_done` or `cfg_abort` pulse.
- R7: A byte write sends the full register index. It enables only lane `index[1:0]` and carries data bits [7:0] in that lane. All other lanes are zero.
- R8: A word write clears index bit 0. It enables lanes 1:0 when index bit 1 is 0, and lanes 3:2 when it is 1. Data bits [15:0] are placed in the enabled lanes.
- R9: Dword writes and reads clear index bits 1:0 and enable all four lanes. `cfg_write` is 1 for writes and 0 for reads. A dword write carries the whole data word.
- R10: When a dword read completes with `cfg_done`, all 32 data bits load from `cfg_rdata` in that cycle.
- R11: In the cycle after `cfg_done` or `cfg_abort`, `cfg_req` is 0 and `reg_ready` is 1. The command field reads 000 and the enable bit keeps its value.
- R12: `cfg_abort` sets the error flag and wins over a simultaneous `cfg_done`. An aborted read leaves the data word unchanged.
- R13: A command write with bit 3 clear, or with code 101..111, is accepted. It stores the enable bit and code but starts no request and leaves the error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register request present |
| reg_ready | output | 1 | High when requests are taken; low means refuse (NACK) |
| reg_write | input | 1 | 1 write, 0 read |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte, same cycle |
| cfg_req | output | 1 | Configuration request valid |
| cfg_write | output | 1 | 1 write, 0 read |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function |
| cfg_reg | output | 8 | Aligned register index |
| cfg_be | output | 4 | Lane byte enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_rdata | input | 32 | Read data from target |
| cfg_done | input | 1 | Completion pulse |
| cfg_abort | input | 1 | Abort pulse |

## Verification
The bound checker covers the request-side rules on every cycle:
- request stability until a response;
- lane counts matching the access size;
- index alignment for word and dword enables;
- release of the request after a response;
- the error flag rising after an abort;
- no request following a disabled command write.

Some behaviour can only be shown by the bench's directed scenarios, because it depends on values the target returns or on register contents seen later through the port:
- exact lane placement of write data;
- capture of read data on a good completion but not on an abort;
- refused writes leaving registers intact;
- status encodings after each kind of ending.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int BYTE_W  = 8;
  localparam int LANES   = 4;
  localparam int WORD_W  = BYTE_W * LANES;
  localparam int OFF_W   = 3;

  localparam logic [2:0] OP_NOP   = 3'b000;
  localparam logic [2:0] OP_WR_B  = 3'b001;
  localparam logic [2:0] OP_WR_W  = 3'b010;
  localparam logic [2:0] OP_WR_D  = 3'b011;
  localparam logic [2:0] OP_RD_D  = 3'b100;

  localparam logic [OFF_W-1:0] OFS_CTRL  = 3'd0;
  localparam logic [OFF_W-1:0] OFS_BUS   = 3'd1;
  localparam logic [OFF_W-1:0] OFS_DEVFN = 3'd2;
  localparam logic [OFF_W-1:0] OFS_INDEX = 3'd3;

  function automatic logic op_is_valid(input logic [2:0] op);
    return (op == OP_WR_B) || (op == OP_WR_W) || (op == OP_WR_D) || (op == OP_RD_D);
  endfunction
endpackage

// File: rtl/smb_cfg_ctrl.sv
module smb_cfg_ctrl
  import smb_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [3:0] ctl_wbits,
  input  logic       rsp_done,
  input  logic       rsp_abort,
  output logic       busy,
  output logic       enable,
  output logic [2:0] op,
  output logic       err,
  output logic       load_rd
);
  logic start;
  assign start   = ctl_wr && !busy && ctl_wbits[3] && op_is_valid(ctl_wbits[2:0]);
  assign load_rd = busy && rsp_done && !rsp_abort && (op == OP_RD_D);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      enable <= 1'b0;
      op     <= OP_NOP;
      err    <= 1'b0;
    end else if (busy) begin
      if (rsp_abort) begin
        busy <= 1'b0;
        err  <= 1'b1;
        op   <= OP_NOP;
      end else if (rsp_done) begin
        busy <= 1'b0;
        op   <= OP_NOP;
      end
    end else if (ctl_wr) begin
      enable <= ctl_wbits[3];
      op     <= ctl_wbits[2:0];
      if (start) begin
        busy <= 1'b1;
        err  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_ofs,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_load,
  input  logic [WORD_W-1:0] rd_word,
  output logic [BYTE_W-1:0] bus_q,
  output logic [BYTE_W-1:0] devfn_q,
  output logic [BYTE_W-1:0] index_q,
  output logic [WORD_W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q   <= '0;
      devfn_q <= '0;
      index_q <= '0;
    end else if (wr_en) begin
      if (wr_ofs == OFS_BUS)   bus_q   <= wr_byte;
      if (wr_ofs == OFS_DEVFN) devfn_q <= wr_byte;
      if (wr_ofs == OFS_INDEX) index_q <= wr_byte;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_data
    localparam logic [OFF_W-1:0] MY_OFS = OFF_W'(LANES + k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        data_q[k*BYTE_W +: BYTE_W] <= '0;
      else if (rd_load)
        data_q[k*BYTE_W +: BYTE_W] <= rd_word[k*BYTE_W +: BYTE_W];
      else if (wr_en && wr_ofs == MY_OFS)
        data_q[k*BYTE_W +: BYTE_W] <= wr_byte;
    end
  end
endmodule

// File: rtl/smb_cfg_lanes.sv
module smb_cfg_lanes
  import smb_cfg_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [BYTE_W-1:0] index,
  input  logic [WORD_W-1:0] data,
  output logic              is_write,
  output logic [BYTE_W-1:0] index_al,
  output logic [LANES-1:0]  be,
  output logic [WORD_W-1:0] wdata
);
  assign is_write = (op != OP_RD_D);

  always_comb begin
    unique case (op)
      OP_WR_B:          index_al = index;
      OP_WR_W:          index_al = {index[BYTE_W-1:1], 1'b0};
      default:          index_al = {index[BYTE_W-1:2], 2'b00};
    endcase
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [1:0] LN = 2'(k);
    logic                en;
    logic [BYTE_W-1:0]   src;
    always_comb begin
      unique case (op)
        OP_WR_B: begin
          en  = (index[1:0] == LN);
          src = data[BYTE_W-1:0];
        end
        OP_WR_W: begin
          en  = (index[1] == LN[1]);
          src = data[(k % 2)*BYTE_W +: BYTE_W];
        end
        default: begin
          en  = 1'b1;
          src = data[k*BYTE_W +: BYTE_W];
        end
      endcase
    end
    assign be[k] = en;
    assign wdata[k*BYTE_W +: BYTE_W] = (en && is_write) ? src : '0;
  end
endmodule

// File: rtl/smb_cfg_engine.sv
module smb_cfg_engine
  import smb_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              cfg_req,
  output logic              cfg_write,
  output logic [BYTE_W-1:0] cfg_bus,
  output logic [BYTE_W-1:0] cfg_devfn,
  output logic [BYTE_W-1:0] cfg_reg,
  output logic [LANES-1:0]  cfg_be,
  output logic [WORD_W-1:0] cfg_wdata,
  input  logic [WORD_W-1:0] cfg_rdata,
  input  logic              cfg_done,
  input  logic              cfg_abort
);
  logic              busy, enable, err_q, load_rd, take_wr;
  logic [2:0]        op;
  logic [BYTE_W-1:0] index_q;
  logic [WORD_W-1:0] data_q;
  logic [BYTE_W-1:0] status;

  assign reg_ready = !busy;
  assign take_wr   = reg_valid && reg_ready && reg_write;
  assign cfg_req   = busy;
  assign status    = {err_q, 3'b000, enable, op};

  smb_cfg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (take_wr && (reg_addr == OFS_CTRL)),
    .ctl_wbits (reg_wdata[3:0]),
    .rsp_done  (cfg_done),
    .rsp_abort (cfg_abort),
    .busy      (busy),
    .enable    (enable),
    .op        (op),
    .err       (err_q),
    .load_rd   (load_rd)
  );

  smb_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take_wr && (reg_addr != OFS_CTRL)),
    .wr_ofs  (reg_addr),
    .wr_byte (reg_wdata),
    .rd_load (load_rd),
    .rd_word (cfg_rdata),
    .bus_q   (cfg_bus),
    .devfn_q (cfg_devfn),
    .index_q (index_q),
    .data_q  (data_q)
  );

  smb_cfg_lanes u_lanes (
    .op       (op),
    .index    (index_q),
    .data     (data_q),
    .is_write (cfg_write),
    .index_al (cfg_reg),
    .be       (cfg_be),
    .wdata    (cfg_wdata)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL:  reg_rdata = status;
      OFS_BUS:   reg_rdata = cfg_bus;
      OFS_DEVFN: reg_rdata = cfg_devfn;
      OFS_INDEX: reg_rdata = index_q;
      default:   reg_rdata = data_q[reg_addr[1:0]*BYTE_W +: BYTE_W];
    endcase
  end
endmodule

// File: rtl/smb_cfg_engine_chk.sv
module smb_cfg_engine_chk
  import smb_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_ready,
  input logic              reg_write,
  input logic [OFF_W-1:0]  reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              cfg_req,
  input logic              cfg_write,
  input logic [BYTE_W-1:0] cfg_reg,
  input logic [LANES-1:0]  cfg_be,
  input logic [WORD_W-1:0] cfg_wdata,
  input logic              cfg_done,
  input logic              cfg_abort,
  input logic              err_flag
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_done && !cfg_abort) |=> (cfg_req && $stable(cfg_reg) && $stable(cfg_be) && $stable(cfg_wdata) && $stable(cfg_write))); // R6

  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 || $countones(cfg_be) == 4)); // R7

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && $countones(cfg_be) == 2) |-> (cfg_reg[0] == 1'b0 && (cfg_be == 4'b0011 || cfg_be == 4'b1100))); // R8

  AST_DWORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && (cfg_be == 4'b1111 || !cfg_write)) |-> (cfg_reg[1:0] == 2'b00 && cfg_be == 4'b1111)); // R9

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && (cfg_done || cfg_abort)) |=> (!cfg_req && reg_ready)); // R11

  AST_ABORT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_abort) |=> err_flag); // R12

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_ready && reg_write && reg_addr == 3'd0 && !reg_wdata[3]) |=> !cfg_req); // R13

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_done && !cfg_abort) |=> !reg_ready); // R5
endmodule

bind smb_cfg_engine smb_cfg_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_ready (reg_ready),
  .reg_write (reg_write),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cfg_req   (cfg_req),
  .cfg_write (cfg_write),
  .cfg_reg   (cfg_reg),
  .cfg_be    (cfg_be),
  .cfg_wdata (cfg_wdata),
  .cfg_done  (cfg_done),
  .cfg_abort (cfg_abort),
  .err_flag  (err_q)
);

// File: tb/smb_cfg_engine_tb.sv
module smb_cfg_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_ready;
  logic [7:0]  reg_rdata;
  logic        cfg_req, cfg_write;
  logic [7:0]  cfg_bus, cfg_devfn, cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata = '0;
  logic        cfg_done = 1'b0, cfg_abort = 1'b0;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  smb_cfg_engine u_dut (.*);

  // target model
  logic [31:0] mem [16];
  int          tgt_mode = 0;  // 0 done, 1 abort, 2 both
  int          wait_cnt = 0, txn_cnt = 0, stab_err = 0;
  logic [7:0]  l_reg, l_bus, l_devfn;
  logic [3:0]  l_be;
  logic [31:0] l_wdata;
  logic        l_write, held = 1'b0;
  logic [44:0] saved;

  initial for (int i = 0; i < 16; i++) mem[i] = '0;

  always @(posedge clk) begin
    cfg_done  <= 1'b0;
    cfg_abort <= 1'b0;
    if (cfg_req && !cfg_done && !cfg_abort) begin
      if (wait_cnt == 2) begin
        wait_cnt <= 0;
        txn_cnt  <= txn_cnt + 1;
        l_reg <= cfg_reg; l_be <= cfg_be; l_wdata <= cfg_wdata; l_write <= cfg_write;
        l_bus <= cfg_bus; l_devfn <= cfg_devfn;
        cfg_rdata <= mem[cfg_reg[5:2]];
        if (tgt_mode != 0) cfg_abort <= 1'b1;
        if (tgt_mode != 1) cfg_done  <= 1'b1;
        if (tgt_mode == 0 && cfg_write)
          for (int b = 0; b < 4; b++)
            if (cfg_be[b]) mem[cfg_reg[5:2]][b*8 +: 8] <= cfg_wdata[b*8 +: 8];
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  // R6: request fields hold while waiting
  always @(posedge clk) begin
    if (held && cfg_req && saved != {cfg_reg, cfg_be, cfg_wdata, cfg_write}) stab_err++;
    held  = cfg_req && !cfg_done && !cfg_abort;
    saved = {cfg_reg, cfg_be, cfg_wdata, cfg_write};
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d, output logic took);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    #1 took = reg_ready;
    @(posedge clk); #1 reg_valid = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (reg_ready) break;
    end
  endtask

  task automatic set_data(input logic [31:0] w);
    logic t;
    for (int k = 0; k < 4; k++) reg_wr(3'(4 + k), w[k*8 +: 8], t);
  endtask

  task automatic get_data(output logic [31:0] w);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin reg_rd(3'(4 + k), b); w[k*8 +: 8] = b; end
  endtask

  task automatic run_cmd(input logic [7:0] c, input string tag);
    logic t;
    reg_wr(3'd0, c, t);
    check({tag, " start accepted"}, {31'd0, t}, 32'd1);
    wait_idle();
  endtask

  task automatic t_reset();
    logic [7:0] b;
    check("R1 ready", {31'd0, reg_ready}, 32'd1);
    check("R1 req", {31'd0, cfg_req}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      reg_rd(3'(a), b);
      check("R1 reg zero", {24'd0, b}, 32'd0);
    end
  endtask

  task automatic t_map();
    logic t; logic [7:0] b; logic [31:0] w;
    reg_wr(3'd1, 8'h12, t); reg_wr(3'd2, 8'h34, t); reg_wr(3'd3, 8'h07, t);
    set_data(32'hA1B2C3D4);
    reg_rd(3'd1, b); check("R2 bus", {24'd0, b}, 32'h12);
    reg_rd(3'd2, b); check("R2 devfn", {24'd0, b}, 32'h34);
    reg_rd(3'd3, b); check("R2 index", {24'd0, b}, 32'h07);
    reg_rd(3'd4, b); check("R2 data byte0", {24'd0, b}, 32'hD4);
    get_data(w); check("R2 data word", w, 32'hA1B2C3D4);
  endtask

  task automatic t_byte_busy();
    logic t; logic [7:0] b;
    reg_wr(3'd0, 8'h09, t);
    check("R4 req after start", {31'd0, cfg_req}, 32'd1);
    check("R4 ready low", {31'd0, reg_ready}, 32'd0);
    reg_wr(3'd1, 8'h99, t);
    check("R5 write refused", {31'd0, t}, 32'd0);
    wait_idle();
    check("R7 index", {24'd0, l_reg}, 32'h07);
    check("R7 be", {28'd0, l_be}, 32'h8);
    check("R7 wdata", l_wdata, 32'hD4000000);
    check("R7 bus/devfn", {16'd0, l_bus, l_devfn}, 32'h1234);
    reg_rd(3'd1, b); check("R5 bus kept", {24'd0, b}, 32'h12);
    reg_rd(3'd0, b); check("R11 R3 status", {24'd0, b}, 32'h08);
  endtask

  task automatic t_word();
    run_cmd(8'h0A, "R8");
    check("R8 index", {24'd0, l_reg}, 32'h06);
    check("R8 be", {28'd0, l_be}, 32'hC);
    check("R8 wdata", l_wdata, 32'hC3D40000);
  endtask

  task automatic t_dword_wr();
    run_cmd(8'h0B, "R9");
    check("R9 index", {24'd0, l_reg}, 32'h04);
    check("R9 be", {28'd0, l_be}, 32'hF);
    check("R9 wdata", l_wdata, 32'hA1B2C3D4);
    check("R9 write flag", {31'd0, l_write}, 32'd1);
  endtask

  task automatic t_dword_rd();
    logic [31:0] w; logic [7:0] b;
    set_data(32'h11223344);
    run_cmd(8'h0C, "R10");
    check("R9 read flag", {31'd0, l_write}, 32'd0);
    check("R9 read index", {24'd0, l_reg}, 32'h04);
    get_data(w); check("R10 captured", w, 32'hA1B2C3D4);
    reg_rd(3'd0, b); check("R11 status after read", {24'd0, b}, 32'h08);
  endtask

  task automatic t_abort_paths();
    logic t; logic [7:0] b; logic [31:0] w; int n;
    tgt_mode = 1;
    run_cmd(8'h0B, "R12");
    reg_rd(3'd0, b); check("R12 abort status", {24'd0, b}, 32'h88);
    tgt_mode = 0;
    n = txn_cnt;
    reg_wr(3'd0, 8'h01, t);
    repeat (6) @(negedge clk);
    check("R13 disabled no txn", n, txn_cnt);
    reg_rd(3'd0, b); check("R13 disabled status", {24'd0, b}, 32'h81);
    reg_wr(3'd0, 8'h0D, t);
    repeat (6) @(negedge clk);
    check("R13 bad code no txn", n, txn_cnt);
    reg_rd(3'd0, b); check("R13 bad code status", {24'd0, b}, 32'h8D);
    run_cmd(8'h0B, "R12");
    reg_rd(3'd0, b); check("R12 err cleared by start", {24'd0, b}, 32'h08);
    set_data(32'h55667788);
    tgt_mode = 2;
    run_cmd(8'h0C, "R12");
    tgt_mode = 0;
    reg_rd(3'd0, b); check("R12 both -> abort", {24'd0, b}, 32'h88);
    get_data(w); check("R12 data not captured", w, 32'h55667788);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_map();
    t_byte_busy();
    t_word();
    t_dword_wr();
    t_dword_rd();
    t_abort_paths();
    check("R6 request stability", stab_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule